// File: doc/BRIEF.md
# Serial Register Access Port

This block is the control port of a peripheral's register bank. The device is the serial master: it generates the serial clock and the outgoing frame sync. It receives 16-bit command frames on a serial data input, and each incoming frame is marked by a host frame-sync pulse on its first bit. Each frame splits into a 10-bit data field and a 6-bit register address, and the block writes the addressed register. The bank holds read-write configuration, an auxiliary power enable, a self-clearing auxiliary reset trigger, and two read-only entries: a fixed identifier and a live status input.

A read takes two steps. The host first writes the wanted address into a dedicated read-select register. After a fixed delay counted in master-clock cycles, the block sends one frame on its serial output without any further request. That frame carries the selected register's contents followed by that register's own address.

Top module: `serial_reg_port`

## Requirements
- R1: Frames are shifted most significant bit first. Frame bit 15 is the first bit received, bits 15..6 are the data and bits 5..0 are the address. A write to address 0x02 loads the configuration register, which is presented on `cfg_q`.
- R2: In the configuration register only bits 4..2 are implemented. The other bits of `cfg_q` stay 0 after any write and read back as 0.
- R3: Address 0x00 (identifier, value `DEV_ID`) and address 0x05 (status, mirrors `status_in`) are read-only. Writes to them leave the value read back unchanged.
- R4: Writes to unmapped addresses change no register. A read of an unmapped address returns data 0 with that address in bits 5..0.
- R5: A write to address 0x0A selects the read address from frame bits 11..6, and frame bits 15..12 are ignored. A read of 0x0A returns the stored select address in data bits 5..0.
- R6: With the default parameters, `sdo_fs` rises exactly 4 `clk` cycles after the clock edge that samples the last bit of a read-select write.
- R7: The read-back frame is 16 bits on `sdo`, MSB first, with data in bits 15..6 and the source address in bits 5..0. `sdo_fs` is high for the first bit period only (`DIV` clk cycles).
- R8: Writing a frame to address 0x04 with data bit 0 set produces a `aux_rst` pulse of exactly one clk cycle. With data bit 0 clear, no pulse appears. Address 0x04 reads back 0.
- R9: `sclk` runs continuously with a period of `DIV` clk cycles. `sdi` is sampled, and `sdo` changes, only at the clk edge where `sclk` rises.
- R10: After reset, `cfg_q`, `aux_pwr_en`, `aux_rst`, `sdo` and `sdo_fs` are 0.
- R11: Writing address 0x03 sets `aux_pwr_en` from data bit 2, which is the only implemented bit there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sdi | input | 1 | Serial command data from host |
| sdi_fs | input | 1 | Host frame sync, high during the first bit of a frame |
| status_in | input | 10 | Live status value shown at address 0x05 |
| sclk | output | 1 | Serial bit clock generated by the block |
| sdo | output | 1 | Serial read-back data |
| sdo_fs | output | 1 | Read-back frame sync, active high |
| cfg_q | output | 10 | Configuration register contents |
| aux_pwr_en | output | 1 | Auxiliary power enable |
| aux_rst | output | 1 | One-cycle auxiliary reset pulse |

## Verification
Two kinds of internal fault show up on the pins. A wrong bit count or a misaligned shift register corrupts the first read-back frame: the address field in bits 5..0 no longer matches the address requested, and this appears within 16 bit periods of the read. A fault in the delay counter or the pending flag moves the rising edge of `sdo_fs` away from its fixed 4-cycle offset, or suppresses it altogether, and this is visible on the next read. A decode fault changes `cfg_q`, `aux_pwr_en` or `aux_rst` within one cycle of the frame's last bit, or returns read-only values that have changed.

// File: rtl/srp_pkg.sv
// Shared constants of the serial register port: frame geometry and
// the register address map. Assumes 16-bit frames, data above address.
package srp_pkg;
    localparam int FRAME_W = 16;
    localparam int DATA_W  = 10;
    localparam int ADDR_W  = 6;

    localparam logic [ADDR_W-1:0] ADR_IDENT  = 6'h00;
    localparam logic [ADDR_W-1:0] ADR_CFG    = 6'h02;
    localparam logic [ADDR_W-1:0] ADR_AUXPWR = 6'h03;
    localparam logic [ADDR_W-1:0] ADR_AUXCTL = 6'h04;
    localparam logic [ADDR_W-1:0] ADR_STATUS = 6'h05;
    localparam logic [ADDR_W-1:0] ADR_RDSEL  = 6'h0A;

    localparam logic [DATA_W-1:0] CFG_MASK   = 10'h01C;
    localparam int                AUXPWR_BIT = 2;
    localparam int                AUXRST_BIT = 0;
endpackage

// File: rtl/srp_clkgen.sv
// Bit-clock generator: divides clk by DIV, raises sclk and a one-cycle
// tick together at each bit boundary. Assumes DIV >= 2.
module srp_clkgen #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick,
    output logic sclk
);
    localparam int CW   = (DIV > 2) ? $clog2(DIV) : 1;
    localparam int HALF = DIV / 2;

    logic [CW-1:0] cnt;

    assign tick = (cnt == CW'(DIV - 1));

    // Free-running divider counter.
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt <= '0;
        else if (tick) cnt <= '0;
        else           cnt <= cnt + 1'b1;
    end

    // Serial clock: high from a bit boundary for HALF cycles.
    always_ff @(posedge clk) begin
        if (!rst_n)                      sclk <= 1'b0;
        else if (tick)                   sclk <= 1'b1;
        else if (cnt == CW'(HALF - 1))   sclk <= 1'b0;
    end
endmodule

// File: rtl/srp_rx.sv
// Frame receiver: starts on a tick with sdi_fs high, shifts 16 bits MSB
// first, and flags the completed word combinationally on its last tick.
module srp_rx
    import srp_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick,
    input  logic               sdi,
    input  logic               sdi_fs,
    output logic               frame_end,
    output logic [FRAME_W-1:0] frame_word
);
    localparam int BW = $clog2(FRAME_W);

    logic               active;
    logic [BW-1:0]      bitcnt;
    logic [FRAME_W-2:0] sh;

    assign frame_end  = tick && active && (bitcnt == BW'(FRAME_W - 1));
    assign frame_word = {sh, sdi};

    // Frame tracking and bit shifting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            bitcnt <= '0;
            sh     <= '0;
        end else if (tick) begin
            if (!active) begin
                if (sdi_fs) begin
                    active <= 1'b1;
                    bitcnt <= BW'(1);
                    sh     <= {sh[FRAME_W-3:0], sdi};
                end
            end else if (frame_end) begin
                active <= 1'b0;
                bitcnt <= '0;
            end else begin
                bitcnt <= bitcnt + 1'b1;
                sh     <= {sh[FRAME_W-3:0], sdi};
            end
        end
    end
endmodule

// File: rtl/srp_regs.sv
// Register bank: decodes a completed frame, updates writable entries,
// raises the read request and muxes the selected register for read-back.
module srp_regs
    import srp_pkg::*;
#(
    parameter logic [9:0] DEV_ID = 10'h2A5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [FRAME_W-1:0] wr_word,
    input  logic [DATA_W-1:0]  status_in,
    output logic [DATA_W-1:0]  cfg_q,
    output logic               aux_pwr_en,
    output logic               aux_rst,
    output logic               rd_go,
    output logic [ADDR_W-1:0]  rd_addr,
    output logic [DATA_W-1:0]  rd_data
);
    logic [ADDR_W-1:0] wa;
    logic [DATA_W-1:0] wd;

    assign wa    = wr_word[ADDR_W-1:0];
    assign wd    = wr_word[FRAME_W-1:ADDR_W];
    assign rd_go = wr_en && (wa == ADR_RDSEL);

    // Writable entries and the read-select register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q      <= '0;
            aux_pwr_en <= 1'b0;
            rd_addr    <= '0;
        end else if (wr_en) begin
            if (wa == ADR_CFG)    cfg_q      <= wd & CFG_MASK;
            if (wa == ADR_AUXPWR) aux_pwr_en <= wd[AUXPWR_BIT];
            if (rd_go)            rd_addr    <= wd[ADDR_W-1:0];
        end
    end

    // Self-clearing auxiliary reset trigger.
    always_ff @(posedge clk) begin
        if (!rst_n) aux_rst <= 1'b0;
        else        aux_rst <= wr_en && (wa == ADR_AUXCTL) && wd[AUXRST_BIT];
    end

    // Read-back source selection.
    always_comb begin
        unique case (rd_addr)
            ADR_IDENT:  rd_data = DEV_ID;
            ADR_CFG:    rd_data = cfg_q;
            ADR_AUXPWR: rd_data = DATA_W'(aux_pwr_en) << AUXPWR_BIT;
            ADR_STATUS: rd_data = status_in;
            ADR_RDSEL:  rd_data = DATA_W'(rd_addr);
            default:    rd_data = '0;
        endcase
    end
endmodule

// File: rtl/srp_tx.sv
// Read-back transmitter: waits RD_DELAY clk cycles after a read request,
// then at the next tick sends data and address MSB first with a frame
// sync on the first bit. Assumes RD_DELAY >= 1.
module srp_tx
    import srp_pkg::*;
#(
    parameter int RD_DELAY = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              rd_go,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [DATA_W-1:0] rd_data,
    output logic              sdo,
    output logic              sdo_fs
);
    localparam int DW = $clog2(RD_DELAY + 1);
    localparam int CW = $clog2(FRAME_W + 1);

    logic [DW-1:0]      dly;
    logic               pending;
    logic               busy;
    logic [CW-1:0]      cnt;
    logic [FRAME_W-1:0] sh;
    logic               launch;
    logic [FRAME_W-1:0] word;

    assign word   = {rd_data, rd_addr};
    assign launch = tick && pending && (dly == '0) && !busy && !rd_go;

    // Request delay and pending flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dly     <= '0;
            pending <= 1'b0;
        end else if (rd_go) begin
            dly     <= DW'(RD_DELAY - 1);
            pending <= 1'b1;
        end else begin
            if (dly != '0) dly     <= dly - 1'b1;
            if (launch)    pending <= 1'b0;
        end
    end

    // Output shifter and frame sync.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            cnt    <= '0;
            sh     <= '0;
            sdo    <= 1'b0;
            sdo_fs <= 1'b0;
        end else if (launch) begin
            busy   <= 1'b1;
            cnt    <= CW'(1);
            sdo    <= word[FRAME_W-1];
            sh     <= {word[FRAME_W-2:0], 1'b0};
            sdo_fs <= 1'b1;
        end else if (tick && busy) begin
            sdo_fs <= 1'b0;
            if (cnt == CW'(FRAME_W)) begin
                busy <= 1'b0;
                cnt  <= '0;
                sdo  <= 1'b0;
            end else begin
                cnt <= cnt + 1'b1;
                sdo <= sh[FRAME_W-1];
                sh  <= {sh[FRAME_W-2:0], 1'b0};
            end
        end
    end
endmodule

// File: rtl/serial_reg_port.sv
// Top of the serial register port: bit clock, receiver, register bank and
// read-back transmitter. The device is serial master on sclk.
module serial_reg_port
    import srp_pkg::*;
#(
    parameter int         DIV      = 4,
    parameter int         RD_DELAY = 4,
    parameter logic [9:0] DEV_ID   = 10'h2A5
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        sdi,
    input  logic        sdi_fs,
    input  logic [9:0]  status_in,
    output logic        sclk,
    output logic        sdo,
    output logic        sdo_fs,
    output logic [9:0]  cfg_q,
    output logic        aux_pwr_en,
    output logic        aux_rst
);
    logic               tick;
    logic               wr_en;
    logic [FRAME_W-1:0] wr_word;
    logic               rd_go;
    logic [ADDR_W-1:0]  rd_addr;
    logic [DATA_W-1:0]  rd_data;

    srp_clkgen #(.DIV(DIV)) u_clk (
        .clk(clk), .rst_n(rst_n), .tick(tick), .sclk(sclk)
    );

    srp_rx u_rx (
        .clk(clk), .rst_n(rst_n), .tick(tick), .sdi(sdi), .sdi_fs(sdi_fs),
        .frame_end(wr_en), .frame_word(wr_word)
    );

    srp_regs #(.DEV_ID(DEV_ID)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_word(wr_word),
        .status_in(status_in), .cfg_q(cfg_q), .aux_pwr_en(aux_pwr_en),
        .aux_rst(aux_rst), .rd_go(rd_go), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    srp_tx #(.RD_DELAY(RD_DELAY)) u_tx (
        .clk(clk), .rst_n(rst_n), .tick(tick), .rd_go(rd_go),
        .rd_addr(rd_addr), .rd_data(rd_data), .sdo(sdo), .sdo_fs(sdo_fs)
    );
endmodule

// File: rtl/serial_reg_port_chk.sv
// Property checker for serial_reg_port, attached by bind below.
module serial_reg_port_chk
    import srp_pkg::*;
#(
    parameter int RD_DELAY = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               sclk,
    input logic               sdo,
    input logic               sdo_fs,
    input logic               aux_rst,
    input logic [9:0]         cfg_q,
    input logic               rd_go,
    input logic               wr_en,
    input logic [FRAME_W-1:0] wr_word
);
    localparam int SW = $clog2(RD_DELAY + 2) + 1;
    localparam logic [SW-1:0] SMAX = '1;

    logic [SW-1:0] since_rd;

    // Cycles since the last read request, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n)              since_rd <= '0;
        else if (rd_go)          since_rd <= '0;
        else if (since_rd != SMAX) since_rd <= since_rd + 1'b1;
    end

    AST_RST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        aux_rst |=> !aux_rst); // R8
    AST_FS_AFTER_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sdo_fs) |-> (since_rd >= SW'(RD_DELAY))); // R6
    AST_SDO_AT_SCLK_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sdo) |-> $rose(sclk)); // R9
    AST_FS_AT_SCLK_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sdo_fs) |-> $rose(sclk)); // R7
    AST_CFG_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cfg_q) |-> $past(wr_en && (wr_word[ADDR_W-1:0] == ADR_CFG))); // R1
endmodule

bind serial_reg_port serial_reg_port_chk #(.RD_DELAY(RD_DELAY)) u_chk (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .sdo(sdo), .sdo_fs(sdo_fs),
    .aux_rst(aux_rst), .cfg_q(cfg_q), .rd_go(rd_go), .wr_en(wr_en),
    .wr_word(wr_word)
);

// File: tb/serial_reg_port_tb.sv
// Directed bench for serial_reg_port: one task per scenario.
module serial_reg_port_tb;
    localparam logic [9:0] ID  = 10'h2A5;
    localparam logic [9:0] STS = 10'h15B;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sdi = 1'b0;
    logic       sdi_fs = 1'b0;
    logic [9:0] status_in = STS;
    logic       sclk, sdo, sdo_fs, aux_pwr_en, aux_rst;
    logic [9:0] cfg_q;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    int t_wr = 0;
    int t_fs = 0;
    int fs_len = 0;
    int pulses = 0;
    logic fs_prev = 1'b0;

    serial_reg_port u_dut (
        .clk(clk), .rst_n(rst_n), .sdi(sdi), .sdi_fs(sdi_fs),
        .status_in(status_in), .sclk(sclk), .sdo(sdo), .sdo_fs(sdo_fs),
        .cfg_q(cfg_q), .aux_pwr_en(aux_pwr_en), .aux_rst(aux_rst)
    );

    always #2.5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    // Frame-sync and reset-pulse monitors, sampled mid-cycle.
    always @(negedge clk) begin
        if (sdo_fs && !fs_prev) begin
            t_fs   = cyc;
            fs_len = 1;
        end else if (sdo_fs) begin
            fs_len = fs_len + 1;
        end
        fs_prev = sdo_fs;
        if (aux_rst) pulses = pulses + 1;
    end

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic send_frame(input logic [15:0] w);
        @(negedge sclk);
        sdi_fs = 1'b1;
        sdi    = w[15];
        for (int i = 14; i >= 0; i--) begin
            @(negedge sclk);
            sdi_fs = 1'b0;
            sdi    = w[i];
        end
        @(posedge sclk);
        @(negedge clk);
        t_wr = cyc;
        @(negedge sclk);
        sdi = 1'b0;
    endtask

    task automatic get_frame(output logic [15:0] w);
        int n = 0;
        w = '0;
        while (!sdo_fs && n < 64) begin
            @(negedge sclk);
            n++;
        end
        w[15] = sdo;
        for (int i = 14; i >= 0; i--) begin
            @(negedge sclk);
            w[i] = sdo;
        end
        @(negedge sclk);
    endtask

    task automatic do_read(input logic [3:0] hi, input logic [5:0] a, output logic [15:0] w);
        send_frame({hi, a, 6'h0A});
        get_frame(w);
    endtask

    task automatic t_reset();
        chk("R10 cfg_q", 16'(cfg_q), 16'h0);
        chk("R10 aux_pwr_en", 16'(aux_pwr_en), 16'h0);
        chk("R10 aux_rst", 16'(aux_rst), 16'h0);
        chk("R10 sdo", 16'(sdo), 16'h0);
        chk("R10 sdo_fs", 16'(sdo_fs), 16'h0);
    endtask

    task automatic t_sclk();
        int a;
        @(posedge sclk); @(negedge clk); a = cyc;
        @(posedge sclk); @(negedge clk);
        chk("R9 sclk period", 16'(cyc - a), 16'd4);
    endtask

    task automatic t_cfg();
        logic [15:0] w;
        send_frame({10'h3FF, 6'h02});
        chk("R2 cfg reserved bits zero", 16'(cfg_q), 16'h001C);
        send_frame({10'h008, 6'h02});
        chk("R1 cfg write", 16'(cfg_q), 16'h0008);
        do_read(4'h0, 6'h02, w);
        chk("R7 cfg read-back frame", w, {10'h008, 6'h02});
        chk("R6 fs delay", 16'(t_fs - t_wr), 16'd4);
        chk("R7 fs width", 16'(fs_len), 16'd4);
    endtask

    task automatic t_readonly();
        logic [15:0] w;
        send_frame({10'h3FF, 6'h00});
        do_read(4'h0, 6'h00, w);
        chk("R3 ident unchanged", w, {ID, 6'h00});
        send_frame({10'h000, 6'h05});
        do_read(4'h0, 6'h05, w);
        chk("R3 status unchanged", w, {STS, 6'h05});
    endtask

    task automatic t_unmapped();
        logic [15:0] w;
        send_frame({10'h3FF, 6'h3F});
        chk("R4 cfg untouched", 16'(cfg_q), 16'h0008);
        chk("R4 pwr untouched", 16'(aux_pwr_en), 16'h0);
        do_read(4'h0, 6'h3F, w);
        chk("R4 unmapped reads zero", w, {10'h000, 6'h3F});
    endtask

    task automatic t_rdsel();
        logic [15:0] w;
        do_read(4'hF, 6'h02, w);
        chk("R5 upper bits ignored", w, {10'h008, 6'h02});
        do_read(4'h5, 6'h0A, w);
        chk("R5 read-select readback", w, {10'h00A, 6'h0A});
        chk("R6 fs delay again", 16'(t_fs - t_wr), 16'd4);
    endtask

    task automatic t_aux();
        int p0;
        logic [15:0] w;
        p0 = pulses;
        send_frame({10'h001, 6'h04});
        repeat (4) @(negedge clk);
        chk("R8 single pulse", 16'(pulses - p0), 16'd1);
        send_frame({10'h3FE, 6'h04});
        repeat (4) @(negedge clk);
        chk("R8 no pulse when bit0 clear", 16'(pulses - p0), 16'd1);
        do_read(4'h0, 6'h04, w);
        chk("R8 aux ctl reads zero", w, {10'h000, 6'h04});
        send_frame({10'h004, 6'h03});
        chk("R11 power enable set", 16'(aux_pwr_en), 16'h1);
        do_read(4'h0, 6'h03, w);
        chk("R11 power readback", w, {10'h004, 6'h03});
        send_frame({10'h3FB, 6'h03});
        chk("R11 power enable cleared", 16'(aux_pwr_en), 16'h0);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_sclk();
        t_cfg();
        t_readonly();
        t_unmapped();
        t_rdsel();
        t_aux();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule